// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block collects interrupt requests from a chip's general-purpose I/O banks and from several other peripherals into one pending-status register. It combines that register with an enable register and drives a single interrupt line to the host. The host reads the status, services every source it finds set, and reads again until the status is zero.

Each I/O bank already combines its own pins into one summary request. These summaries sit in the lowest status bits and track their banks, delayed by one register stage. Requests from the other peripherals are latched, and each latched bit stays set until the host clears it. A clear takes effect only once the source has dropped its request. The enable register holds a global enable and one enable per status bit. The host sees interrupts as rising edges. An acknowledge that arrives while work is still pending therefore pulls the output low for one cycle, so that a fresh edge follows.

The output is driven by a three-state machine. `ST_IDLE` holds the line low. `ST_RAISED` holds it high. `ST_GAP` holds it low for exactly one cycle after an acknowledge. The transitions are:
- IDLE→RAISED when gated work is pending.
- RAISED→IDLE when no gated work remains.
- RAISED→GAP on an acknowledge while work remains.
- GAP→RAISED if work remains.
- GAP→IDLE otherwise.

Top module: `irq_status_agg`

## Requirements
- R1: After reset the status reads zero while all requests are low, the enable register reads zero, and the interrupt output is low.
- R2: Status bits 0 to 3 equal the summary requests of banks 0 to 3, in that order, one clock after the requests are applied. A later change of a request is followed in the same way.
- R3: Peripheral request k (k = 0..5) sets status bit 4+k one clock after it is high. The bit stays set after the request falls.
- R4: A write to the status address (address 1'b0) clears each peripheral status bit whose data bit is 1, but only if that source's request is low at that clock. Writes have no effect on status bits 0 to 3.
- R5: The enable register is at address 1'b1. Bit 0 is the global enable and bit 1+n enables status bit n. Enables are active high. Bits 15 to 11 read as zero, and a written value reads back masked to bits 10:0.
- R6: When the global enable is set and an enabled status bit is set, the interrupt output is high from the second clock after the status bit becomes set.
- R7: While the global enable is clear, the interrupt output stays low whatever the status and the per-source enables are.
- R8: A status bit whose enable is clear does not raise the interrupt output.
- R9: An acknowledge pulse sampled while the output is high and gated work remains drives the output low for exactly one cycle, after which it is high again.
- R10: When no enabled status bit remains set, the output is low one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bank_req | input | 4 | Summary requests from I/O banks 0..3 |
| periph_req | input | 6 | Requests from the other peripherals |
| reg_addr | input | 1 | Register select: 0 status, 1 enables |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the selected register |
| irq_ack | input | 1 | Host acknowledge pulse |
| irq | output | 1 | Interrupt output to the host |

## Verification
The hardest situation to reach from the ports is the GAP state followed directly by a new rising edge. It needs an acknowledge to land in a cycle where the output is high and gated work still exists. The bench holds one peripheral request high and applies the acknowledge at a falling edge. It then samples the output on the next two falling edges, expecting low and then high. The same sequence is repeated after the request is released and the bit is cleared, where the output must stay low.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int unsigned BANKS   = 4;
    localparam int unsigned PERIPHS = 6;
    localparam int unsigned REG_W   = 16;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RAISED = 2'd1,
        ST_GAP    = 2'd2
    } irq_state_t;
endpackage

// File: rtl/irq_stat_reg.sv
module irq_stat_reg #(
    parameter int unsigned NB = 4,
    parameter int unsigned NP = 6,
    localparam int unsigned NS = NB + NP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] bank_req,
    input  logic [NP-1:0] periph_req,
    input  logic          clr_en,
    input  logic [NS-1:0] clr_bits,
    output logic [NS-1:0] stat_q
);
    // Bank summaries: one register stage, no memory.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q[NB-1:0] <= '0;
        else        stat_q[NB-1:0] <= bank_req;
    end

    // Peripheral bits: set by request, cleared by host only once the source is idle.
    for (genvar k = 0; k < NP; k++) begin : g_periph
        logic clr_ok;
        assign clr_ok = clr_en && clr_bits[NB+k] && !periph_req[k];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             stat_q[NB+k] <= 1'b0;
            else if (periph_req[k]) stat_q[NB+k] <= 1'b1;
            else if (clr_ok)        stat_q[NB+k] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int unsigned MW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [MW-1:0] wdata,
    output logic [MW-1:0] mask_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wdata;
    end
endmodule

// File: rtl/irq_out_fsm.sv
module irq_out_fsm
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic ack,
    output logic irq
);
    irq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (pending) state_d = ST_RAISED;
            ST_RAISED: begin
                if (!pending)  state_d = ST_IDLE;
                else if (ack)  state_d = ST_GAP;
            end
            ST_GAP:    state_d = pending ? ST_RAISED : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        irq = (state_q == ST_RAISED);
    end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
    import irq_agg_pkg::*;
#(
    parameter int unsigned NB = BANKS,
    parameter int unsigned NP = PERIPHS,
    parameter int unsigned DW = REG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] bank_req,
    input  logic [NP-1:0] periph_req,
    input  logic          reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          irq_ack,
    output logic          irq
);
    localparam int unsigned NS = NB + NP;
    localparam int unsigned MW = NS + 1;

    logic [NS-1:0] stat_q;
    logic [MW-1:0] mask_q;
    logic          pending;
    logic          wr_stat, wr_mask;

    assign wr_stat = reg_wr && (reg_addr == 1'b0);
    assign wr_mask = reg_wr && (reg_addr == 1'b1);

    irq_stat_reg #(.NB(NB), .NP(NP)) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_req   (bank_req),
        .periph_req (periph_req),
        .clr_en     (wr_stat),
        .clr_bits   (reg_wdata[NS-1:0]),
        .stat_q     (stat_q)
    );

    irq_mask_reg #(.MW(MW)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_mask),
        .wdata  (reg_wdata[MW-1:0]),
        .mask_q (mask_q)
    );

    assign pending = mask_q[0] && (|(stat_q & mask_q[MW-1:1]));

    irq_out_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .ack     (irq_ack),
        .irq     (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == 1'b0) reg_rdata[NS-1:0] = stat_q;
        else                  reg_rdata[MW-1:0] = mask_q;
    end
endmodule

// File: rtl/irq_status_agg_chk.sv
module irq_status_agg_chk #(
    parameter int unsigned NB = 4,
    parameter int unsigned NP = 6,
    localparam int unsigned NS = NB + NP
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NB-1:0] bank_req,
    input logic [NP-1:0] periph_req,
    input logic          reg_wr,
    input logic          irq_ack,
    input logic          irq,
    input logic [NS-1:0] stat_q,
    input logic [NS:0]   mask_q
);
    logic gated;
    assign gated = mask_q[0] && (|(stat_q & mask_q[NS:1]));

    a_r2_bank_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stat_q[NB-1:0] == $past(bank_req));

    a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (stat_q[NS-1:NB] & $past(periph_req)) == $past(periph_req));

    a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> (stat_q[NS-1:NB] & $past(stat_q[NS-1:NB])) == $past(stat_q[NS-1:NB]));

    a_r7_global_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[0] |=> !irq);

    a_r6_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && gated) |=> irq);

    a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && irq_ack && gated) |=> !irq);

    a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !gated |=> !irq);
endmodule

bind irq_status_agg irq_status_agg_chk #(.NB(NB), .NP(NP)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bank_req   (bank_req),
    .periph_req (periph_req),
    .reg_wr     (reg_wr),
    .irq_ack    (irq_ack),
    .irq        (irq),
    .stat_q     (stat_q),
    .mask_q     (mask_q)
);

// File: tb/irq_status_agg_tb.sv
module irq_status_agg_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bank_req = '0;
    logic [5:0]  periph_req = '0;
    logic        reg_addr = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_ack = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    irq_status_agg u_dut (
        .clk(clk), .rst_n(rst_n), .bank_req(bank_req), .periph_req(periph_req),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_ack(irq_ack), .irq(irq)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick(1);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_all();
        periph_req = '0; bank_req = '0;
        tick(1);
        wr(1'b0, 16'h03F0);
        tick(2);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] v;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd(1'b0, v); chk("R1 status", v, 16'h0000);
        rd(1'b1, v); chk("R1 mask", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);

        // R2 bank sweep, bits 0..3
        for (int p = 0; p < 16; p++) begin
            bank_req = p[3:0];
            tick(1);
            rd(1'b0, v); chk("R2 bank follow", v, {12'd0, p[3:0]});
        end
        bank_req = '0; tick(1);

        // R3 each peripheral at bit 4+k, sticky
        for (int k = 0; k < 6; k++) begin
            periph_req = 6'b1 << k;
            tick(1);
            periph_req = '0;
            tick(3);
            rd(1'b0, v); chk("R3 sticky bit", v, 16'h0010 << k);
            wr(1'b0, 16'h0010 << k);
            rd(1'b0, v); chk("R4 cleared", v, 16'h0000);
        end

        // R4 clear blocked while source high; bank bits unaffected
        bank_req = 4'hF; periph_req = 6'b000101;
        tick(1);
        periph_req = 6'b000001;
        wr(1'b0, 16'hFFFF);
        rd(1'b0, v); chk("R4 held source survives", v, 16'h001F);
        periph_req = '0; bank_req = '0;
        tick(1);
        wr(1'b0, 16'h0010);
        rd(1'b0, v); chk("R4 clear after release", v, 16'h0000);

        // R5 mask readback
        for (int m = 0; m < 8; m++) begin
            logic [15:0] w;
            w = 16'h9A5B * (m + 1) ^ (16'hF0F0 >> m);
            wr(1'b1, w);
            rd(1'b1, v); chk("R5 mask readback", v, w & 16'h07FF);
        end
        wr(1'b1, 16'h0000);

        // R6/R8 per source, enabled alone vs all others enabled
        for (int s = 0; s < 10; s++) begin
            for (int e = 0; e < 2; e++) begin
                logic [9:0] en;
                en = (e == 0) ? (10'd1 << s) : ~(10'd1 << s);
                wr(1'b1, {5'd0, en, 1'b1});
                if (s < 4) bank_req = 4'd1 << s;
                else       periph_req = 6'd1 << (s - 4);
                tick(1);
                chk(e == 0 ? "R6 no rise before 2nd clock" : "R8 early", {15'd0, irq}, 16'h0000);
                tick(1);
                chk(e == 0 ? "R6 enabled source raises" : "R8 masked source quiet",
                    {15'd0, irq}, (e == 0) ? 16'h0001 : 16'h0000);
                clear_all();
                chk("R10 drop after clear", {15'd0, irq}, 16'h0000);
            end
        end

        // R7 global enable off
        wr(1'b1, 16'h07FE);
        bank_req = 4'hF; periph_req = 6'h3F;
        tick(4);
        chk("R7 global off", {15'd0, irq}, 16'h0000);
        wr(1'b1, 16'h07FF);
        tick(1);
        chk("R7 global on", {15'd0, irq}, 16'h0001);
        wr(1'b1, 16'h07FE);
        tick(1);
        chk("R7 global cleared drops", {15'd0, irq}, 16'h0000);
        clear_all();

        // R9 acknowledge with work remaining
        wr(1'b1, 16'h07FF);
        periph_req = 6'b000010;
        tick(3);
        chk("R9 raised", {15'd0, irq}, 16'h0001);
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
        chk("R9 gap low", {15'd0, irq}, 16'h0000);
        tick(1);
        chk("R9 re-raised", {15'd0, irq}, 16'h0001);
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
        chk("R9 second gap", {15'd0, irq}, 16'h0000);
        tick(1);
        chk("R9 second re-raise", {15'd0, irq}, 16'h0001);

        // R10 release and clear: ack then no re-raise
        periph_req = '0; tick(1);
        wr(1'b0, 16'h0020);
        tick(1);
        chk("R10 low after clear", {15'd0, irq}, 16'h0000);
        irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
        tick(2);
        chk("R10 stays low", {15'd0, irq}, 16'h0000);
        rd(1'b0, v); chk("R10 status zero", v, 16'h0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule